// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides the output clock of an external dual-modulus prescaler so that the overall division from the oscillator is N = P·B + A. P is the smaller prescaler modulus. The block runs on the prescaler output clock. A programmable counter loaded with B counts every prescaler cycle. A swallow counter loaded with A counts down alongside it. While the swallow counter is nonzero, the modulus-control output asks the prescaler for P+1. After it reaches zero, the output asks for P. When the programmable counter runs out, both counters reload, and a one-cycle pulse goes to the phase detector.

Control logic writes A, B and a two-bit prescaler code together as one word. A write whose values cannot be divided correctly is refused and flagged. Values that are accepted are held in a latch and used from the next reload onward. A period that is already running is never changed by a write.

Two hold inputs, one for counter reset and one for power-down, keep both counters parked at their load values. This lets the divider restart in step with the reference divider. Counting starts again on the first clock edge at which neither hold input is asserted.

Top module: `ps_swallow_div`

## Requirements
- R1: While `rst_n` is low, and directly after it, `div_pulse`, `mod_ctl`, `cfg_err` and `presc_sel` are all 0. The latched defaults are A=0, B=16 and code 0.
- R2: In free run, `div_pulse` is high for exactly one clock cycle. Successive pulses are exactly B clock cycles apart.
- R3: Count the pulse cycle as cycle 1 of a period. `mod_ctl` (1 = request P+1) is high in cycles 1..A and low for the rest of the period. Summing P+1 for each high cycle and P for each low cycle over one period gives P·B+A.
- R4: `presc_sel` carries the code in use: 0 → 8/9, 1 → 16/17, 2 → 32/33, 3 → 64/65. It changes only in a pulse cycle or while held.
- R5: A write (`wr_en`=1) is accepted only when `wr_b` ≥ 3 and `wr_b` ≥ `wr_a`. The edge B = A is allowed. A refused write leaves the divider unchanged. `cfg_err` is 1 from the cycle after a refused write until the next accepted write, and 0 after an accepted one.
- R6: Values from an accepted write that arrives in the middle of a period do not change that period. They first take effect in the period that starts with the next pulse.
- R7: While `cnt_rst` or `pwr_dn` is high, no pulse is produced. One cycle after any write, `mod_ctl` shows (latched A ≠ 0) and `presc_sel` shows the latched code.
- R8: After both hold inputs go low, count the first rising edge that samples them low as edge 1. The first pulse appears after edge B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Counter reset; holds both counters at their load values |
| pwr_dn | input | 1 | Power-down; holds both counters at their load values |
| wr_en | input | 1 | Write strobe for the A/B/code word |
| wr_a | input | 6 | Swallow count A |
| wr_b | input | 12 | Programmable count B |
| wr_sel | input | 2 | Prescaler code |
| mod_ctl | output | 1 | 1 requests modulus P+1, 0 requests P |
| presc_sel | output | 2 | Prescaler code in use |
| div_pulse | output | 1 | One-cycle pulse per divide period |
| cfg_err | output | 1 | Last write was refused |

## Verification
A wrong count in the programmable counter shows up as a pulse spacing other than B. It appears at the very next pulse, and a period measurement catches it. A wrong swallow count, or a reload that ends early, shifts the number of `mod_ctl` high cycles. That in turn moves the oscillator cycle total away from P·B+A within the same period. A latch that applies values at the wrong time shows up in the one period that straddles the write. A hold release that is mishandled moves the first pulse away from edge B, and this is visible one period after release.

// File: rtl/ps_div_pkg.sv
package ps_div_pkg;
   typedef enum logic [1:0] {
      PS_8_9   = 2'd0,
      PS_16_17 = 2'd1,
      PS_32_33 = 2'd2,
      PS_64_65 = 2'd3
   } psel_e;

   localparam int PS_SEL_W    = 2;
   localparam int PS_A_W      = 6;
   localparam int PS_B_W      = 12;
   localparam int PS_B_MIN    = 3;
   localparam int PS_BASE_LOG = 3;

   function automatic int unsigned presc_base(input logic [PS_SEL_W-1:0] code);
      return 32'd1 << (PS_BASE_LOG + int'(code));
   endfunction
endpackage

// File: rtl/ps_cfg_latch.sv
module ps_cfg_latch
   import ps_div_pkg::*;
#(
   parameter int A_W   = PS_A_W,
   parameter int B_W   = PS_B_W,
   parameter int B_MIN = PS_B_MIN,
   parameter int RST_A = 0,
   parameter int RST_B = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [A_W-1:0]      wr_a,
   input  logic [B_W-1:0]      wr_b,
   input  logic [PS_SEL_W-1:0] wr_sel,
   output logic [A_W-1:0]      lat_a,
   output logic [B_W-1:0]      lat_b,
   output logic [PS_SEL_W-1:0] lat_sel,
   output logic                err
);
   localparam logic [B_W-1:0] BMIN_V = B_W'(B_MIN);

   logic word_ok;
   assign word_ok = (wr_b >= BMIN_V) && (B_W'(wr_a) <= wr_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_a   <= A_W'(RST_A);
         lat_b   <= B_W'(RST_B);
         lat_sel <= PS_8_9;
         err     <= 1'b0;
      end else if (wr_en) begin
         err <= ~word_ok;
         if (word_ok) begin
            lat_a   <= wr_a;
            lat_b   <= wr_b;
            lat_sel <= wr_sel;
         end
      end
   end
endmodule

// File: rtl/ps_swallow_ctr.sv
module ps_swallow_ctr #(
   parameter int A_W   = 6,
   parameter int RST_A = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [A_W-1:0] load_val,
   output logic           swallow
);
   logic [A_W-1:0] a_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               a_cnt <= A_W'(RST_A);
      else if (load)            a_cnt <= load_val;
      else if (a_cnt != '0)     a_cnt <= a_cnt - A_W'(1);
   end

   assign swallow = (a_cnt != '0);
endmodule

// File: rtl/ps_prog_ctr.sv
module ps_prog_ctr #(
   parameter int B_W       = 12,
   parameter int RST_B     = 16,
   parameter bit PULSE_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic [B_W-1:0] load_val,
   output logic           term,
   output logic           pulse
);
   logic [B_W-1:0] b_cnt;

   assign term = (b_cnt == B_W'(1)) && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            b_cnt <= B_W'(RST_B);
      else if (hold || term) b_cnt <= load_val;
      else                   b_cnt <= b_cnt - B_W'(1);
   end

   generate
      if (PULSE_REG) begin : g_pulse_reg
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= term;
         end
         assign pulse = pulse_q;
      end else begin : g_pulse_comb
         assign pulse = term;
      end
   endgenerate
endmodule

// File: rtl/ps_swallow_div.sv
module ps_swallow_div
   import ps_div_pkg::*;
#(
   parameter int A_W       = PS_A_W,
   parameter int B_W       = PS_B_W,
   parameter int B_MIN     = PS_B_MIN,
   parameter int RST_A     = 0,
   parameter int RST_B     = 16,
   parameter bit PULSE_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cnt_rst,
   input  logic                pwr_dn,
   input  logic                wr_en,
   input  logic [A_W-1:0]      wr_a,
   input  logic [B_W-1:0]      wr_b,
   input  logic [PS_SEL_W-1:0] wr_sel,
   output logic                mod_ctl,
   output logic [PS_SEL_W-1:0] presc_sel,
   output logic                div_pulse,
   output logic                cfg_err
);
   generate
      if (A_W > B_W) begin : g_bad_width
         $error("swallow counter wider than programmable counter");
      end
      if (B_MIN < 2) begin : g_bad_bmin
         $error("B_MIN must be at least 2");
      end
      if (RST_B < B_MIN || RST_A > RST_B) begin : g_bad_rst
         $error("reset divide values break the write rule");
      end
   endgenerate

   logic                hold, term, load;
   logic [A_W-1:0]      lat_a;
   logic [B_W-1:0]      lat_b;
   logic [PS_SEL_W-1:0] lat_sel;
   logic [PS_SEL_W-1:0] sel_q;

   assign hold = cnt_rst | pwr_dn;
   assign load = hold | term;

   ps_cfg_latch #(
      .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN), .RST_A(RST_A), .RST_B(RST_B)
   ) u_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_a(wr_a), .wr_b(wr_b),
      .wr_sel(wr_sel), .lat_a(lat_a), .lat_b(lat_b), .lat_sel(lat_sel),
      .err(cfg_err)
   );

   ps_swallow_ctr #(.A_W(A_W), .RST_A(RST_A)) u_swallow (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(lat_a),
      .swallow(mod_ctl)
   );

   ps_prog_ctr #(.B_W(B_W), .RST_B(RST_B), .PULSE_REG(PULSE_REG)) u_prog (
      .clk(clk), .rst_n(rst_n), .hold(hold), .load_val(lat_b),
      .term(term), .pulse(div_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel_q <= PS_8_9;
      else if (load) sel_q <= lat_sel;
   end

   assign presc_sel = sel_q;
endmodule

// File: rtl/ps_swallow_div_chk.sv
module ps_swallow_div_chk #(
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_rst,
   input logic             pwr_dn,
   input logic             wr_en,
   input logic             mod_ctl,
   input logic [SEL_W-1:0] presc_sel,
   input logic             div_pulse,
   input logic             cfg_err
);
   logic hold;
   assign hold = cnt_rst | pwr_dn;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse); // R2

   AST_MOD_RISE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_ctl) |-> (div_pulse || $past(hold))); // R3

   AST_SEL_CHANGE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(presc_sel) |-> (div_pulse || $past(hold))); // R4

   AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> $past(wr_en)); // R5

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_err)); // R5

   AST_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !div_pulse); // R7
endmodule

bind ps_swallow_div ps_swallow_div_chk #(.SEL_W(ps_div_pkg::PS_SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
   .wr_en(wr_en), .mod_ctl(mod_ctl), .presc_sel(presc_sel),
   .div_pulse(div_pulse), .cfg_err(cfg_err)
);

// File: tb/tb_ps_swallow_div.sv
module tb_ps_swallow_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_rst = 1'b0, pwr_dn = 1'b0, wr_en = 1'b0;
   logic [5:0]  wr_a = '0;
   logic [11:0] wr_b = '0;
   logic [1:0]  wr_sel = '0;
   logic        mod_ctl, div_pulse, cfg_err;
   logic [1:0]  presc_sel;

   always #2.5 clk = ~clk; // 200 MHz

   ps_swallow_div dut (
      .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
      .wr_en(wr_en), .wr_a(wr_a), .wr_b(wr_b), .wr_sel(wr_sel),
      .mod_ctl(mod_ctl), .presc_sel(presc_sel), .div_pulse(div_pulse),
      .cfg_err(cfg_err)
   );

   int checks = 0, fails = 0;
   int cyc = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // period monitor
   int  cur_len, cur_mod, cur_vco, last_len, last_mod, last_vco;
   int  npulse = 0, wide = 0;
   bit  valid = 0, prev_pulse = 0;

   always @(negedge clk) begin
      int contrib;
      cyc++;
      contrib = (8 << presc_sel) + (mod_ctl ? 1 : 0);
      if (!rst_n || cnt_rst || pwr_dn) begin
         valid = 0; cur_len = 0; cur_mod = 0; cur_vco = 0;
      end else if (div_pulse) begin
         if (prev_pulse) wide++;
         if (valid) begin
            last_len = cur_len; last_mod = cur_mod; last_vco = cur_vco;
         end
         npulse++;
         valid = 1;
         cur_len = 1; cur_mod = mod_ctl ? 1 : 0; cur_vco = contrib;
      end else if (valid) begin
         cur_len++; cur_mod += mod_ctl ? 1 : 0; cur_vco += contrib;
      end
      prev_pulse = div_pulse;
      if (cyc > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wr(input int a, input int b, input int s);
      @(negedge clk);
      wr_en = 1'b1; wr_a = 6'(a); wr_b = 12'(b); wr_sel = 2'(s);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_pulses(input int n);
      int target;
      target = npulse + n;
      wait (npulse >= target);
      @(negedge clk);
   endtask

   task automatic release_and_count(input string tag, input int exp_b);
      int n;
      @(negedge clk);
      cnt_rst = 1'b0; pwr_dn = 1'b0;
      n = 0;
      do begin
         @(posedge clk); n++;
         @(negedge clk);
      end while (!div_pulse && n < 5000);
      chk(tag, n, exp_b);
   endtask

   // {sel, a, b}
   localparam logic [19:0] VEC [7] = '{
      {2'd0, 6'd0,  12'd3},
      {2'd0, 6'd3,  12'd3},
      {2'd1, 6'd5,  12'd20},
      {2'd2, 6'd63, 12'd63},
      {2'd3, 6'd10, 12'd40},
      {2'd1, 6'd0,  12'd100},
      {2'd2, 6'd7,  12'd12}
   };

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 pulse in reset", int'(div_pulse), 0);
      chk("R1 mod in reset", int'(mod_ctl), 0);
      chk("R1 err in reset", int'(cfg_err), 0);
      chk("R1 sel in reset", int'(presc_sel), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mod after reset", int'(mod_ctl), 0);
      wait_pulses(2);
      chk("R2 default period 16", last_len, 16);

      // table walk: R2, R3, R4, R6
      for (int i = 0; i < 7; i++) begin
         int s, a, b;
         s = int'(VEC[i][19:18]); a = int'(VEC[i][17:12]); b = int'(VEC[i][11:0]);
         wr(a, b, s);
         chk("R5 valid write err", int'(cfg_err), 0);
         wait_pulses(3);
         chk("R2 period", last_len, b);
         chk("R3 mod cycles", last_mod, a);
         chk("R3 vco total", last_vco, (8 << s) * b + a);
         chk("R4 sel code", int'(presc_sel), s);
      end
      chk("R2 pulse width", wide, 0);

      // R7/R8 counter-reset hold
      @(negedge clk); cnt_rst = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R7 no pulse in hold", int'(div_pulse), 0);
      end
      chk("R7 mod in hold A=7", int'(mod_ctl), 1);
      chk("R7 sel in hold", int'(presc_sel), 2);
      wr(0, 10, 3);
      @(negedge clk);
      chk("R7 mod after write A=0", int'(mod_ctl), 0);
      chk("R7 sel after write", int'(presc_sel), 3);
      release_and_count("R8 first pulse after cnt_rst", 10);

      // R7/R8 power-down hold
      @(negedge clk); pwr_dn = 1'b1;
      wr(4, 25, 1);
      repeat (2) @(negedge clk);
      chk("R7 mod in powerdown A=4", int'(mod_ctl), 1);
      chk("R7 no pulse in powerdown", int'(div_pulse), 0);
      release_and_count("R8 first pulse after pwr_dn", 25);
      wait_pulses(2);
      chk("R8 period after release", last_len, 25);

      // R5 refused words
      wr(30, 20, 0);
      chk("R5 A above B err", int'(cfg_err), 1);
      wr(0, 2, 0);
      chk("R5 B below 3 err", int'(cfg_err), 1);
      repeat (4) @(negedge clk);
      chk("R5 err held", int'(cfg_err), 1);
      wait_pulses(2);
      chk("R5 refused word ignored", last_len, 25);
      chk("R5 refused A ignored", last_mod, 4);
      wr(25, 25, 0);
      chk("R5 B equal A accepted", int'(cfg_err), 0);
      wait_pulses(2);
      chk("R5 B equal A mod", last_mod, 25);

      // R6 mid-period write
      wait_pulses(1);
      repeat (5) @(negedge clk);
      wr(2, 40, 0);
      wait_pulses(1);
      chk("R6 running period unchanged", last_len, 25);
      wait_pulses(1);
      chk("R6 new period", last_len, 40);
      chk("R6 new vco total", last_vco, 8 * 40 + 2);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule